// File: doc/BRIEF.md
# Multi-core inter-processor mailbox

This block links one host processor (index 0) with three peer processors through a set of register windows. Each processor has its own 32-bit register port (address, write enable, write data, read data) and its own interrupt line. Address bits [13:12] choose a window, and each window pairs the accessing processor with one other processor. The window for another processor `q` sits in slot `q` when `q` is lower than the caller's index, and in slot `q-1` otherwise. On the host this places the windows for peers 1, 2 and 3 at 0x0000, 0x1000 and 0x2000.

A window holds a doorbell (generate) register, seven payload words and an acknowledge word. The payload and acknowledge words are stored once per processor pair, so both sides see the same storage. Each processor also has a status register and a mask register, which every one of its windows aliases. When a processor writes the doorbell register with the data bit or the acknowledge bit set, the receiving processor latches a status bit for that sender. The receiver's interrupt is raised while any latched bit is also enabled in its mask.

The register port has no handshake. Every access completes in the cycle it is presented, and the bus never applies back-pressure. Reads are combinational from the current address.

Top module: `mbox_top`

## Requirements
- R1: After reset the status, mask, doorbell and message words of every processor read as zero, and every interrupt output is low.
- R2: Offsets inside a window are: status at 0x00 (read-only; writes have no effect), clear at 0x04 (reads as zero), mask at 0x0C, doorbell at 0x10, and message word k at 0x14+4k for k = 0..7. Word 7 (0x30) is the acknowledge word. Address bits [13:12] select the window slot.
- R3: A write to the doorbell register with bit 6 (data) or bit 7 (acknowledge) set sets the receiver's status bit for the sender at the next clock edge. A doorbell write with both bits clear sets nothing.
- R4: The status and mask bit for sender `s` at receiver `r` is `s` when `s < r` and `s-1` otherwise. At the host, peers 1, 2 and 3 map to bits 0, 1 and 2.
- R5: Writing ones to the clear register clears the matching status bits, and 0xFF clears all of them. When a set and a clear hit the same bit in the same cycle, the set wins.
- R6: Each interrupt output is a register loaded with the OR of (status AND mask) over the processor's three bits. It therefore follows status or mask changes one clock later. The mask resets to zero, which disables every source.
- R7: The doorbell register reads back the full byte last written to it through that window.
- R8: The message words of a pair are one shared store. A word written by either processor reads back at the same offset through the other processor's window. If both write the same word in the same cycle, the processor with the lower index wins.
- R9: Reads of unmapped locations return zero, and writes to them change nothing. Unmapped locations are window slots 3 and above, offset 0x08, offsets above 0x30, and misaligned offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | N*AW | Byte address for each processor, processor p at bits [p*AW +: AW] |
| cpu_we | input | N | Write enable for each processor |
| cpu_wdata | input | N*32 | Write data for each processor |
| cpu_rdata | output | N*32 | Combinational read data for each processor |
| cpu_irq | output | N | Registered interrupt for each processor |

## Verification
Directed cases separate the bit mapping of each sender and receiver pair, using a doorbell from peer 3 to the host and one from the host to peer 2. They also show that a doorbell byte without bit 6 or 7 leaves status untouched. Further directed cases place a clear and a set on the same cycle to expose the priority, and check the interrupt one cycle after the mask write to expose its register stage. Two processors write one shared word in the same cycle to show which index wins. Writes to a high slot, a hole offset, an offset past the last word and a misaligned offset confirm that nothing leaks into mapped storage. Constrained random traffic then mixes doorbell, clear, mask and word writes from all four ports at once. Its reads are compared against a bench model, which separates wrong slot-to-peer routing and pair indexing from simple readback faults.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned WIN_AW = 12;
  localparam int unsigned NWORD = 8;
  localparam int unsigned WIDX_W = $clog2(NWORD);
  localparam int unsigned GEN_W = 8;
  localparam int unsigned BELL_DATA = 6;
  localparam int unsigned BELL_ACK = 7;

  localparam logic [WIN_AW-1:0] OFF_STAT = 12'h000;
  localparam logic [WIN_AW-1:0] OFF_CLR = 12'h004;
  localparam logic [WIN_AW-1:0] OFF_MASK = 12'h00C;
  localparam logic [WIN_AW-1:0] OFF_GEN = 12'h010;
  localparam logic [WIN_AW-1:0] OFF_WORD0 = 12'h014;
  localparam logic [WIN_AW-1:0] OFF_WLAST = 12'h030;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_STAT,
    RK_CLR,
    RK_MASK,
    RK_GEN,
    RK_WORD
  } reg_kind_e;

  // Window slot (or status bit) for processor "other" as seen by processor "me".
  function automatic int unsigned compact(input int unsigned me, input int unsigned other);
    return (other < me) ? other : other - 1;
  endfunction

  // Processor reached through slot "slot" of processor "me".
  function automatic int unsigned peer_of(input int unsigned me, input int unsigned slot);
    return (slot < me) ? slot : slot + 1;
  endfunction

  // Index of the unordered processor pair {a, b} among n processors.
  function automatic int unsigned pair_of(input int unsigned a, input int unsigned b,
                                          input int unsigned n);
    int unsigned lo;
    int unsigned hi;
    int unsigned idx;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    idx = 0;
    for (int unsigned i = 0; i < lo; i++) idx += n - 1 - i;
    return idx + hi - lo - 1;
  endfunction
endpackage

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned AW = 14,
  localparam int unsigned SW = N - 1,
  localparam int unsigned SLW = AW - WIN_AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr,
  input  logic                     we,
  input  logic [GEN_W-1:0]         wbyte,
  input  logic [SW-1:0]            status_q,
  input  logic [SW-1:0]            mask_q,
  input  logic [SW*NWORD*DW-1:0]   slot_words,
  output logic [DW-1:0]            rdata,
  output logic [SLW-1:0]           slot,
  output logic [WIDX_W-1:0]        word_idx,
  output logic                     gen_fire,
  output logic                     clr_we,
  output logic                     mask_we,
  output logic                     word_we
);
  logic [WIN_AW-1:0] off;
  logic              slot_ok;
  reg_kind_e         kind;
  logic [SW*GEN_W-1:0] gen_q;

  assign slot     = addr[AW-1:WIN_AW];
  assign off      = addr[WIN_AW-1:0];
  assign slot_ok  = (int'(slot) < int'(SW));
  assign word_idx = WIDX_W'((off - OFF_WORD0) >> 2);

  always_comb begin
    kind = RK_NONE;
    if (slot_ok) begin
      if (off == OFF_STAT) kind = RK_STAT;
      else if (off == OFF_CLR) kind = RK_CLR;
      else if (off == OFF_MASK) kind = RK_MASK;
      else if (off == OFF_GEN) kind = RK_GEN;
      else if (off >= OFF_WORD0 && off <= OFF_WLAST && off[1:0] == 2'b00) kind = RK_WORD;
    end
  end

  assign clr_we   = we && (kind == RK_CLR);
  assign mask_we  = we && (kind == RK_MASK);
  assign word_we  = we && (kind == RK_WORD);
  assign gen_fire = we && (kind == RK_GEN) && (wbyte[BELL_DATA] || wbyte[BELL_ACK]);

  for (genvar s = 0; s < SW; s++) begin : g_gen
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gen_q[s*GEN_W +: GEN_W] <= '0;
      else if (we && kind == RK_GEN && slot == SLW'(s)) gen_q[s*GEN_W +: GEN_W] <= wbyte;
    end
  end

  always_comb begin
    rdata = '0;
    case (kind)
      RK_STAT: rdata[SW-1:0] = status_q;
      RK_MASK: rdata[SW-1:0] = mask_q;
      RK_GEN:  rdata[GEN_W-1:0] = gen_q[int'(slot)*GEN_W +: GEN_W];
      RK_WORD: rdata = slot_words[(int'(slot)*int'(NWORD) + int'(word_idx))*int'(DW) +: DW];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbox_rx_status.sv
module mbox_rx_status #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_bits,
  input  logic [SW-1:0] clr_bits,
  input  logic          mask_we,
  input  logic [SW-1:0] mask_d,
  output logic [SW-1:0] status_q,
  output logic [SW-1:0] mask_q,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_bits) | set_bits;
      if (mask_we) mask_q <= mask_d;
      irq <= |(status_q & mask_q);
    end
  end
endmodule

// File: rtl/mbox_pair_store.sv
module mbox_pair_store
  import mbox_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lo_we,
  input  logic [WIDX_W-1:0]     lo_idx,
  input  logic [DW-1:0]         lo_data,
  input  logic                  hi_we,
  input  logic [WIDX_W-1:0]     hi_idx,
  input  logic [DW-1:0]         hi_data,
  output logic [NWORD*DW-1:0]   words_q
);
  for (genvar w = 0; w < NWORD; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words_q[w*DW +: DW] <= '0;
      else if (lo_we && lo_idx == WIDX_W'(w)) words_q[w*DW +: DW] <= lo_data;
      else if (hi_we && hi_idx == WIDX_W'(w)) words_q[w*DW +: DW] <= hi_data;
    end
  end
endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned AW = 14,
  localparam int unsigned SW = N - 1,
  localparam int unsigned SLW = AW - WIN_AW,
  localparam int unsigned NPAIR = N * (N - 1) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N*AW-1:0]   cpu_addr,
  input  logic [N-1:0]      cpu_we,
  input  logic [N*DW-1:0]   cpu_wdata,
  output logic [N*DW-1:0]   cpu_rdata,
  output logic [N-1:0]      cpu_irq
);
  logic [SLW-1:0]       slot_idx [N];
  logic [WIDX_W-1:0]    word_idx [N];
  logic [N-1:0]         gen_fire;
  logic [N-1:0]         clr_we;
  logic [N-1:0]         mask_we;
  logic [N-1:0]         word_we;
  logic [SW-1:0]        status_q [N];
  logic [SW-1:0]        mask_q [N];
  logic [NWORD*DW-1:0]  pair_q [NPAIR];
  logic [N*SW-1:0]      status_flat;
  logic [N*SW-1:0]      mask_flat;
  logic [N*SW-1:0]      set_flat;
  logic [N*SW-1:0]      clr_flat;

  for (genvar p = 0; p < N; p++) begin : g_cpu
    logic [SW*NWORD*DW-1:0] slot_words;
    logic [SW-1:0]          setv;
    logic [SW-1:0]          clrv;

    for (genvar s = 0; s < SW; s++) begin : g_slot
      assign slot_words[s*NWORD*DW +: NWORD*DW] = pair_q[pair_of(p, peer_of(p, s), N)];
      assign setv[s] = gen_fire[peer_of(p, s)] &&
                       (slot_idx[peer_of(p, s)] == SLW'(compact(peer_of(p, s), p)));
    end

    assign clrv = clr_we[p] ? cpu_wdata[p*DW +: SW] : '0;

    mbox_port #(.N(N), .AW(AW)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (cpu_addr[p*AW +: AW]),
      .we         (cpu_we[p]),
      .wbyte      (cpu_wdata[p*DW +: GEN_W]),
      .status_q   (status_q[p]),
      .mask_q     (mask_q[p]),
      .slot_words (slot_words),
      .rdata      (cpu_rdata[p*DW +: DW]),
      .slot       (slot_idx[p]),
      .word_idx   (word_idx[p]),
      .gen_fire   (gen_fire[p]),
      .clr_we     (clr_we[p]),
      .mask_we    (mask_we[p]),
      .word_we    (word_we[p])
    );

    mbox_rx_status #(.SW(SW)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (setv),
      .clr_bits (clrv),
      .mask_we  (mask_we[p]),
      .mask_d   (cpu_wdata[p*DW +: SW]),
      .status_q (status_q[p]),
      .mask_q   (mask_q[p]),
      .irq      (cpu_irq[p])
    );

    assign status_flat[p*SW +: SW] = status_q[p];
    assign mask_flat[p*SW +: SW]   = mask_q[p];
    assign set_flat[p*SW +: SW]    = setv;
    assign clr_flat[p*SW +: SW]    = clrv;
  end

  for (genvar a = 0; a < N; a++) begin : g_lo
    for (genvar b = a + 1; b < N; b++) begin : g_hi
      mbox_pair_store u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_we   (word_we[a] && (slot_idx[a] == SLW'(compact(a, b)))),
        .lo_idx  (word_idx[a]),
        .lo_data (cpu_wdata[a*DW +: DW]),
        .hi_we   (word_we[b] && (slot_idx[b] == SLW'(compact(b, a)))),
        .hi_idx  (word_idx[b]),
        .hi_data (cpu_wdata[b*DW +: DW]),
        .words_q (pair_q[pair_of(a, b, N)])
      );
    end
  end
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
  import mbox_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned AW = 14,
  localparam int unsigned SW = N - 1,
  localparam int unsigned SLW = AW - WIN_AW
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N*AW-1:0] cpu_addr,
  input logic [N*DW-1:0] cpu_rdata,
  input logic [N-1:0]    cpu_irq,
  input logic [N*SW-1:0] status_flat,
  input logic [N*SW-1:0] mask_flat,
  input logic [N*SW-1:0] set_flat,
  input logic [N*SW-1:0] clr_flat
);
  function automatic logic loc_mapped(input logic [AW-1:0] a);
    logic [WIN_AW-1:0] o;
    o = a[WIN_AW-1:0];
    if (int'(a[AW-1:WIN_AW]) >= int'(SW)) return 1'b0;
    if (o == OFF_STAT || o == OFF_CLR || o == OFF_MASK || o == OFF_GEN) return 1'b1;
    return (o >= OFF_WORD0 && o <= OFF_WLAST && o[1:0] == 2'b00);
  endfunction

  for (genvar i = 0; i < N*SW; i++) begin : g_bit
    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      set_flat[i] |=> status_flat[i]); // R3
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_flat[i] && !set_flat[i]) |=> !status_flat[i]); // R5
    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_flat[i] && !set_flat[i]) |=> $stable(status_flat[i])); // R5
  end

  for (genvar r = 0; r < N; r++) begin : g_cpu
    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status_flat[r*SW +: SW] & mask_flat[r*SW +: SW])) |=> cpu_irq[r]); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_flat[r*SW +: SW] == '0) |=> !cpu_irq[r]); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !loc_mapped(cpu_addr[r*AW +: AW]) |-> (cpu_rdata[r*DW +: DW] == '0)); // R9
  end
endmodule

bind mbox_top mbox_chk #(.N(N), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_rdata   (cpu_rdata),
  .cpu_irq     (cpu_irq),
  .status_flat (status_flat),
  .mask_flat   (mask_flat),
  .set_flat    (set_flat),
  .clr_flat    (clr_flat)
);

// File: tb/mbox_top_tb.sv
module mbox_top_tb;
  localparam int N = 4;
  localparam int AW = 14;
  localparam int DW = 32;
  localparam int SW = 3;
  localparam int NPAIR = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N*AW-1:0]   cpu_addr = '0;
  logic [N-1:0]      cpu_we = '0;
  logic [N*DW-1:0]   cpu_wdata = '0;
  wire  [N*DW-1:0]   cpu_rdata;
  wire  [N-1:0]      cpu_irq;

  always #5 clk = ~clk;

  mbox_top #(.N(N), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_irq(cpu_irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  bit [2:0]  m_st [N];
  bit [2:0]  m_mk [N];
  bit        m_irq [N];
  bit [7:0]  m_gen [N][SW];
  bit [31:0] m_wd [NPAIR][8];

  function automatic int b_cmp(int me, int other);
    return (other < me) ? other : other - 1;
  endfunction
  function automatic int b_peer(int me, int sl);
    return (sl < me) ? sl : sl + 1;
  endfunction
  function automatic int b_pair(int a, int b);
    int lo = (a < b) ? a : b;
    int hi = (a < b) ? b : a;
    int idx = 0;
    for (int i = 0; i < lo; i++) idx += N - 1 - i;
    return idx + hi - lo - 1;
  endfunction
  function automatic bit is_word(logic [11:0] o);
    return (o >= 12'h014 && o <= 12'h030 && o[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] m_read(int p, logic [13:0] a);
    int sl = int'(a[13:12]);
    logic [11:0] o = a[11:0];
    if (sl >= SW) return 32'h0;
    if (o == 12'h000) return {29'h0, m_st[p]};
    if (o == 12'h00C) return {29'h0, m_mk[p]};
    if (o == 12'h010) return {24'h0, m_gen[p][sl]};
    if (is_word(o)) return m_wd[b_pair(p, b_peer(p, sl))][int'(o - 12'h014) >> 2];
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [13:0] a);
    logic [11:0] o = a[11:0];
    if (int'(a[13:12]) >= SW) return "R9";
    if (o == 12'h000) return "R3";
    if (o == 12'h004) return "R2";
    if (o == 12'h00C) return "R6";
    if (o == 12'h010) return "R7";
    if (is_word(o)) return "R8";
    return "R9";
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_port(int p, logic [13:0] a, logic w, logic [31:0] d);
    cpu_addr[p*AW +: AW] = a;
    cpu_we[p] = w;
    cpu_wdata[p*DW +: DW] = d;
  endtask

  // One clock: model follows the inputs currently driven, then realign at negedge.
  task automatic step();
    bit [2:0]  clr [N];
    bit [2:0]  setb [N];
    bit [2:0]  mk_n [N];
    bit [7:0]  gen_n [N][SW];
    bit [31:0] wd_n [NPAIR][8];
    bit        irq_n [N];
    mk_n = m_mk;
    gen_n = m_gen;
    wd_n = m_wd;
    for (int r = 0; r < N; r++) begin
      irq_n[r] = |(m_st[r] & m_mk[r]);
      clr[r] = '0;
      setb[r] = '0;
    end
    for (int p = N - 1; p >= 0; p--) begin
      if (cpu_we[p]) begin
        logic [13:0] a = cpu_addr[p*AW +: AW];
        logic [31:0] d = cpu_wdata[p*DW +: DW];
        int sl = int'(a[13:12]);
        logic [11:0] o = a[11:0];
        if (sl < SW) begin
          int pe = b_peer(p, sl);
          if (o == 12'h004) clr[p] |= d[2:0];
          else if (o == 12'h00C) mk_n[p] = d[2:0];
          else if (o == 12'h010) begin
            gen_n[p][sl] = d[7:0];
            if (d[6] || d[7]) setb[pe][b_cmp(pe, p)] = 1'b1;
          end else if (is_word(o)) wd_n[b_pair(p, pe)][int'(o - 12'h014) >> 2] = d;
        end
      end
    end
    @(posedge clk);
    for (int r = 0; r < N; r++) m_st[r] = (m_st[r] & ~clr[r]) | setb[r];
    m_mk = mk_n;
    m_gen = gen_n;
    m_wd = wd_n;
    m_irq = irq_n;
    @(negedge clk);
  endtask

  task automatic quiet();
    cpu_we = '0;
  endtask

  task automatic read_chk(int p, logic [13:0] a, string req);
    set_port(p, a, 1'b0, 32'h0);
    #1;
    chk(cpu_rdata[p*DW +: DW], m_read(p, a), req, $sformatf("cpu%0d read %h", p, a));
    step();
  endtask

  task automatic read_exp(int p, logic [13:0] a, logic [31:0] exp, string req);
    set_port(p, a, 1'b0, 32'h0);
    #1;
    chk(cpu_rdata[p*DW +: DW], exp, req, $sformatf("cpu%0d read %h", p, a));
    step();
  endtask

  task automatic irq_chk(string req);
    for (int r = 0; r < N; r++) chk({31'h0, cpu_irq[r]}, {31'h0, m_irq[r]}, req, $sformatf("irq%0d", r));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5EED));
    for (int r = 0; r < N; r++) begin
      m_st[r] = '0; m_mk[r] = '0; m_irq[r] = 1'b0;
      for (int s = 0; s < SW; s++) m_gen[r][s] = '0;
    end
    for (int q = 0; q < NPAIR; q++) for (int w = 0; w < 8; w++) m_wd[q][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    irq_chk("R1");
    for (int p = 0; p < N; p++) begin
      read_exp(p, 14'h0000, 32'h0, "R1");
      read_exp(p, 14'h100C, 32'h0, "R1");
      read_exp(p, 14'h2010, 32'h0, "R1");
      read_exp(p, 14'h0030, 32'h0, "R1");
    end

    // R4: peer 3 rings host (slot 0 of cpu3) -> host bit 2
    set_port(3, 14'h0010, 1'b1, 32'h40);
    step(); quiet();
    read_exp(0, 14'h0000, 32'h4, "R4");
    // R3: host rings peer 2 with ack bit (host slot 1) -> cpu2 bit 0
    set_port(0, 14'h1010, 1'b1, 32'h80);
    step(); quiet();
    read_exp(2, 14'h0000, 32'h1, "R3");
    // R3: doorbell byte without bit 6/7 sets nothing; R7: readback
    set_port(1, 14'h0010, 1'b1, 32'h3F);
    step(); quiet();
    read_exp(0, 14'h2000, 32'h4, "R3");
    read_exp(1, 14'h0010, 32'h3F, "R7");
    read_exp(3, 14'h0010, 32'h40, "R7");

    // R6: mask enables host bit 2; irq lags by one register
    chk({31'h0, cpu_irq[0]}, 32'h0, "R6", "irq0 while masked");
    set_port(0, 14'h000C, 1'b1, 32'h4);
    step(); quiet();
    chk({31'h0, cpu_irq[0]}, 32'h0, "R6", "irq0 same edge as mask");
    step();
    chk({31'h0, cpu_irq[0]}, 32'h1, "R6", "irq0 one edge after mask");

    // R5: set beats clear in the same cycle
    set_port(1, 14'h0010, 1'b1, 32'h40);
    set_port(0, 14'h0004, 1'b1, 32'h7);
    step(); quiet();
    read_exp(0, 14'h0000, 32'h1, "R5");
    set_port(0, 14'h0004, 1'b1, 32'hFF);
    step(); quiet();
    read_exp(0, 14'h0000, 32'h0, "R5");
    // R2: status is read-only, clear reads zero
    set_port(0, 14'h0000, 1'b1, 32'h7);
    step(); quiet();
    read_exp(0, 14'h0000, 32'h0, "R2");
    read_exp(0, 14'h0004, 32'h0, "R2");

    // R8: shared pair storage and lower-index priority
    set_port(0, 14'h0020, 1'b1, 32'hA5A5_1234);
    step(); quiet();
    read_exp(1, 14'h0020, 32'hA5A5_1234, "R8");
    set_port(1, 14'h1014, 1'b1, 32'h1111_1111);
    set_port(2, 14'h1014, 1'b1, 32'h2222_2222);
    step(); quiet();
    read_exp(2, 14'h1014, 32'h1111_1111, "R8");

    // R9: unmapped writes and reads
    set_port(0, 14'h3014, 1'b1, 32'hDEAD_0001);
    set_port(1, 14'h0008, 1'b1, 32'hDEAD_0002);
    set_port(2, 14'h0034, 1'b1, 32'hDEAD_0003);
    set_port(3, 14'h0015, 1'b1, 32'hDEAD_0004);
    step(); quiet();
    read_exp(0, 14'h3014, 32'h0, "R9");
    read_exp(1, 14'h0008, 32'h0, "R9");
    read_exp(2, 14'h0034, 32'h0, "R9");
    read_exp(3, 14'h0015, 32'h0, "R9");
    read_exp(3, 14'h0014, 32'h0, "R9");
    read_exp(2, 14'h0030, 32'h0, "R9");

    // Constrained random traffic from all ports
    for (int it = 0; it < 500; it++) begin
      for (int p = 0; p < N; p++) begin
        if ($urandom % 10 < 6) begin
          int sl = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
          int k = int'($urandom % 12);
          logic [11:0] o;
          if (k == 0) o = 12'h000;
          else if (k == 1) o = 12'h004;
          else if (k == 2) o = 12'h00C;
          else if (k < 5) o = 12'h010;
          else if (k < 9) o = 12'h014 + 12'(4 * ($urandom % 8));
          else if (k == 9) o = 12'h008;
          else if (k == 10) o = 12'h034;
          else o = 12'h015 + 12'(4 * ($urandom % 4));
          set_port(p, {2'(sl), o}, 1'b1, $urandom);
        end else begin
          cpu_we[p] = 1'b0;
        end
      end
      step(); quiet();
      irq_chk("R6");
      for (int p = 0; p < N; p++) begin
        logic [13:0] a = {2'($urandom % 4), 12'(($urandom % 16) * 4)};
        read_chk(p, a, tag_of(a));
      end
      irq_chk("R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule